// File: doc/BRIEF.md
# Conversion Frame Serial Master

This block is the host side of a 16-clock full-duplex serial link to a multichannel successive-approximation converter. A start request makes it drop an active-low select line, wait a setup window, and run sixteen serial clock cycles. It derives the serial clock from the system clock through a parameterised half-period count. During those cycles it sends a 16-bit control word to the converter and gathers the converter's 16-bit reply.

The reply carries its own header. Three channel-identification bits come first, then a sign bit, then a 12-bit magnitude, all most significant bit first. The block splits the reply into those three fields and presents them with a one-cycle valid strobe. After each frame it keeps the select line high and refuses new requests until both the quiet interval and the minimum select-high interval have passed. A busy output tells the host when a request would be accepted.

Top module: `adc_frame_master`

## Requirements
- R1: After a synchronous reset, selN and serClk are 1 and busy and resValid are 0.
- R2: A request on startReq is taken at a clock edge only when busy is 0 in that cycle, and selN goes low in the next cycle. A request made while busy is 1 is ignored and leaves selN high.
- R3: After selN falls, serClk stays high for SETUP_CYC system cycles before its first falling edge.
- R4: A frame has exactly 16 serClk low phases of DIV_HALF cycles each, separated by 15 high phases of DIV_HALF cycles. In the cycle after the 16th low phase, serClk and selN both return to 1.
- R5: serOut carries ctrlWord bit 15 first and bit 0 last. Bit 15 is the write-enable bit and bits 14 and 13 are the register-select bits. The first bit is presented from the cycle selN falls, and serOut changes only in a cycle where serClk has just risen, so each bit is steady across the falling edge that samples it.
- R6: The first reply bit is sampled from serIn at the end of the setup window. Each later bit is sampled at the serClk rising edge that follows the falling edge that launched it, for 16 bits in all.
- R7: resValid is high for exactly one cycle, the first cycle in which selN is high again. In that cycle resChan holds reply bits 15..13, resSign holds reply bit 12, and resData holds reply bits 11..0.
- R8: Starting with the cycle selN rises, busy stays high for max(QUIET_CYC, CSHIGH_CYC) cycles and then falls, so selN stays high for at least that many cycles plus one.
- R9: serClk is high in every cycle in which selN is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| startReq | input | 1 | Request to run one frame |
| ctrlWord | input | 16 | Control word sent during the frame |
| busy | output | 1 | High while a request would be refused |
| selN | output | 1 | Active-low converter select |
| serClk | output | 1 | Serial clock, idles high |
| serOut | output | 1 | Serial data to the converter |
| serIn | input | 1 | Serial data from the converter |
| resValid | output | 1 | One-cycle result strobe |
| resChan | output | 3 | Channel identifier from the reply header |
| resSign | output | 1 | Sign bit from the reply |
| resData | output | 12 | Magnitude bits from the reply |

## Verification
The bench builds the block with DIV_HALF=2, SETUP_CYC=3, QUIET_CYC=3 and CSHIGH_CYC=5. Short phases keep every frame only a few dozen cycles long, so many frames fit into one run. The select-high minimum is set larger than the quiet time, which exposes any logic that times the gap with the wrong of the two limits. A setup window longer than a clock half-period also makes a miscounted first falling edge visible. Running requests back to back, with startReq held high, puts the gap boundary and the refusal of early requests under every-cycle comparison.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH
  } frameState_t;

  // Strobes from the sequencer to the shift datapath, valid for one cycle.
  typedef struct packed {
    logic loadWord;    // accept edge: load the outgoing word
    logic captureBit;  // sample the incoming serial line
    logic shiftOut;    // advance the outgoing bit
    logic finish;      // frame complete: publish the result
  } frameStrobes_t;

endpackage

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
  import adc_frame_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int DIV_HALF   = 7,
  parameter int SETUP_CYC  = 2,
  parameter int QUIET_CYC  = 4,
  parameter int CSHIGH_CYC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          startReq,
  output logic          busy,
  output logic          selN,
  output logic          serClk,
  output frameStrobes_t strb
);

  localparam int MAX_PH = (DIV_HALF > SETUP_CYC) ? DIV_HALF : SETUP_CYC;
  localparam int PH_W   = $clog2(MAX_PH + 1);
  localparam int GAP    = (QUIET_CYC > CSHIGH_CYC) ? QUIET_CYC : CSHIGH_CYC;
  localparam int GAP_W  = $clog2(GAP + 1);
  localparam int BIT_W  = $clog2(WORD_W);

  frameState_t state, stateNext;
  logic [PH_W-1:0]  phaseCnt, phaseNext;
  logic [BIT_W-1:0] bitCnt, bitNext;
  logic [GAP_W-1:0] gapCnt, gapNext;
  logic             phaseDone;
  logic             lastBit;

  assign phaseDone = (phaseCnt == '0);
  assign lastBit   = (bitCnt == BIT_W'(WORD_W - 1));

  always_comb begin
    stateNext = state;
    phaseNext = phaseCnt;
    bitNext   = bitCnt;
    gapNext   = (gapCnt != '0) ? gapCnt - 1'b1 : gapCnt;
    strb      = '0;
    unique case (state)
      ST_IDLE: begin
        if (startReq && (gapCnt == '0)) begin
          stateNext     = ST_SETUP;
          phaseNext     = PH_W'(SETUP_CYC - 1);
          bitNext       = '0;
          strb.loadWord = 1'b1;
        end
      end
      ST_SETUP: begin
        if (phaseDone) begin
          stateNext       = ST_LOW;
          phaseNext       = PH_W'(DIV_HALF - 1);
          strb.captureBit = 1'b1;
        end else begin
          phaseNext = phaseCnt - 1'b1;
        end
      end
      ST_LOW: begin
        if (phaseDone) begin
          if (lastBit) begin
            stateNext   = ST_IDLE;
            gapNext     = GAP_W'(GAP);
            strb.finish = 1'b1;
          end else begin
            stateNext       = ST_HIGH;
            phaseNext       = PH_W'(DIV_HALF - 1);
            strb.captureBit = 1'b1;
            strb.shiftOut   = 1'b1;
          end
        end else begin
          phaseNext = phaseCnt - 1'b1;
        end
      end
      ST_HIGH: begin
        if (phaseDone) begin
          stateNext = ST_LOW;
          phaseNext = PH_W'(DIV_HALF - 1);
          bitNext   = bitCnt + 1'b1;
        end else begin
          phaseNext = phaseCnt - 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      bitCnt   <= '0;
      gapCnt   <= '0;
      selN     <= 1'b1;
      serClk   <= 1'b1;
    end else begin
      state    <= stateNext;
      phaseCnt <= phaseNext;
      bitCnt   <= bitNext;
      gapCnt   <= gapNext;
      selN     <= (stateNext == ST_IDLE);
      serClk   <= (stateNext != ST_LOW);
    end
  end

  assign busy = (state != ST_IDLE) || (gapCnt != '0);

endmodule

// File: rtl/adc_frame_dp.sv
module adc_frame_dp
  import adc_frame_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CHAN_W = 3,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  frameStrobes_t     strb,
  input  logic [WORD_W-1:0] ctrlWord,
  input  logic              serIn,
  output logic              serOut,
  output logic              resValid,
  output logic [CHAN_W-1:0] resChan,
  output logic              resSign,
  output logic [DATA_W-1:0] resData
);

  localparam int SIGN_POS = DATA_W;
  localparam int CHAN_LO  = DATA_W + 1;

  logic [WORD_W-1:0] txReg;
  logic [WORD_W-1:0] rxReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      txReg <= '0;
    end else if (strb.loadWord) begin
      txReg <= ctrlWord;
    end else if (strb.shiftOut) begin
      txReg <= {txReg[WORD_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rxReg <= '0;
    end else if (strb.captureBit) begin
      rxReg <= {rxReg[WORD_W-2:0], serIn};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resValid <= 1'b0;
      resChan  <= '0;
      resSign  <= 1'b0;
      resData  <= '0;
    end else begin
      resValid <= strb.finish;
      if (strb.finish) begin
        resChan <= rxReg[CHAN_LO +: CHAN_W];
        resSign <= rxReg[SIGN_POS];
        resData <= rxReg[DATA_W-1:0];
      end
    end
  end

  assign serOut = txReg[WORD_W-1];

endmodule

// File: rtl/adc_frame_master.sv
module adc_frame_master
  import adc_frame_pkg::*;
#(
  parameter int DIV_HALF   = 7,
  parameter int SETUP_CYC  = 2,
  parameter int QUIET_CYC  = 4,
  parameter int CSHIGH_CYC = 2,
  parameter int CHAN_W     = 3,
  parameter int DATA_W     = 12,
  localparam int WORD_W    = CHAN_W + 1 + DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              startReq,
  input  logic [WORD_W-1:0] ctrlWord,
  output logic              busy,
  output logic              selN,
  output logic              serClk,
  output logic              serOut,
  input  logic              serIn,
  output logic              resValid,
  output logic [CHAN_W-1:0] resChan,
  output logic              resSign,
  output logic [DATA_W-1:0] resData
);

  frameStrobes_t strb;

  adc_frame_ctrl #(
    .WORD_W(WORD_W), .DIV_HALF(DIV_HALF), .SETUP_CYC(SETUP_CYC),
    .QUIET_CYC(QUIET_CYC), .CSHIGH_CYC(CSHIGH_CYC)
  ) u_ctrl (
    .clk(clk), .rst(rst), .startReq(startReq), .busy(busy),
    .selN(selN), .serClk(serClk), .strb(strb)
  );

  adc_frame_dp #(
    .WORD_W(WORD_W), .CHAN_W(CHAN_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .ctrlWord(ctrlWord),
    .serIn(serIn), .serOut(serOut), .resValid(resValid),
    .resChan(resChan), .resSign(resSign), .resData(resData)
  );

endmodule

// File: rtl/adc_frame_checks.sv
module adc_frame_checks (
  input logic clk,
  input logic rst,
  input logic startReq,
  input logic busy,
  input logic selN,
  input logic serClk,
  input logic resValid
);

  assert_idle_select_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> selN);

  assert_start_gated_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(selN) |-> ($past(startReq) && !$past(busy)));

  assert_fall_in_frame_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(serClk) |-> (!selN && !$past(selN)));

  assert_valid_single_R7: assert property (@(posedge clk) disable iff (rst)
    resValid |=> !resValid);

  assert_valid_at_rise_R7: assert property (@(posedge clk) disable iff (rst)
    resValid |-> $rose(selN));

  assert_gap_busy_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(selN) |-> busy);

  assert_clock_idle_high_R9: assert property (@(posedge clk) disable iff (rst)
    selN |-> serClk);

endmodule

bind adc_frame_master adc_frame_checks u_chk (
  .clk(clk), .rst(rst), .startReq(startReq), .busy(busy),
  .selN(selN), .serClk(serClk), .resValid(resValid)
);

// File: tb/sim_adc_frame_master.sv
`timescale 1ns/1ps
module sim_adc_frame_master;

  localparam int DIV   = 2;
  localparam int SETUP = 3;
  localparam int QUIET = 3;
  localparam int CSHI  = 5;
  localparam int GAP   = (QUIET > CSHI) ? QUIET : CSHI;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic startReq = 1'b0;
  logic [15:0] ctrlWord = '0;
  logic busy, selN, serClk, serOut;
  logic serIn = 1'b0;
  logic resValid, resSign;
  logic [2:0] resChan;
  logic [11:0] resData;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [15:0] devWord = '0;
  logic [15:0] dinCap = '0;
  int fallCnt = 0;
  int frames = 0;

  logic [3:0] expQ[$];
  logic prevSclk = 1'b1, prevSel = 1'b1, prevOut = 1'b0;

  always #4 clk = ~clk;

  adc_frame_master #(
    .DIV_HALF(DIV), .SETUP_CYC(SETUP), .QUIET_CYC(QUIET), .CSHIGH_CYC(CSHI)
  ) u0 (
    .clk(clk), .rst(rst), .startReq(startReq), .ctrlWord(ctrlWord),
    .busy(busy), .selN(selN), .serClk(serClk), .serOut(serOut),
    .serIn(serIn), .resValid(resValid), .resChan(resChan),
    .resSign(resSign), .resData(resData)
  );

  // Converter model: header bit appears at select fall, later bits after falls.
  always @(negedge selN) begin
    fallCnt = 0;
    dinCap  = '0;
    serIn   = devWord[15];
  end

  always @(negedge serClk) begin
    if (!selN) begin
      dinCap  = {dinCap[14:0], serOut};
      fallCnt = fallCnt + 1;
      serIn   = (fallCnt < 16) ? devWord[15 - fallCnt] : 1'b0;
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", what, act, exp, $time);
    end
  endtask

  // Reference model: expected {selN, serClk, busy, resValid} per cycle.
  always @(negedge clk) begin
    logic [3:0] e;
    if (!rst) begin
      e = (expQ.size() > 0) ? expQ.pop_front() : 4'b1100;
      chk(selN == e[3], "R2 R3 selN", int'(selN), int'(e[3]));
      chk(serClk == e[2], "R4 R9 serClk", int'(serClk), int'(e[2]));
      chk(busy == e[1], "R2 R8 busy", int'(busy), int'(e[1]));
      chk(resValid == e[0], "R7 resValid", int'(resValid), int'(e[0]));
      if (resValid) begin
        frames++;
        chk(resChan == devWord[15:13], "R6 R7 resChan", int'(resChan), int'(devWord[15:13]));
        chk(resSign == devWord[12], "R6 R7 resSign", int'(resSign), int'(devWord[12]));
        chk(resData == devWord[11:0], "R6 R7 resData", int'(resData), int'(devWord[11:0]));
        chk(dinCap == ctrlWord, "R5 serOut word", int'(dinCap), int'(ctrlWord));
      end
      if (!selN && !prevSel && serOut != prevOut)
        chk(serClk && !prevSclk, "R5 serOut change point", int'(serClk), 1);
      if (!selN && prevSel)
        chk(serOut == ctrlWord[15], "R5 first bit at select fall", int'(serOut), int'(ctrlWord[15]));
      if (!e[1] && startReq) begin
        for (int i = 0; i < SETUP; i++) expQ.push_back(4'b0110);
        for (int b = 0; b < 16; b++) begin
          for (int i = 0; i < DIV; i++) expQ.push_back(4'b0010);
          if (b < 15) for (int i = 0; i < DIV; i++) expQ.push_back(4'b0110);
        end
        expQ.push_back(4'b1111);
        for (int i = 1; i < GAP; i++) expQ.push_back(4'b1110);
      end
      prevSclk = serClk;
      prevSel  = selN;
      prevOut  = serOut;
    end
  end

  task automatic drive_cycles(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #2;
  endtask

  task automatic wait_idle();
    @(posedge clk);
    while (busy) @(posedge clk);
    #2;
  endtask

  task automatic one_frame(input logic [15:0] cw, input logic [15:0] dw);
    ctrlWord = cw;
    devWord  = dw;
    startReq = 1'b1;
    drive_cycles(1);
    startReq = 1'b0;
    // R2: a request raised mid-frame must be ignored
    drive_cycles(10);
    startReq = 1'b1;
    drive_cycles(1);
    startReq = 1'b0;
    wait_idle();
  endtask

  initial begin
    drive_cycles(3);
    chk(selN == 1'b1, "R1 reset selN", int'(selN), 1);
    chk(serClk == 1'b1, "R1 reset serClk", int'(serClk), 1);
    chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);
    chk(resValid == 1'b0, "R1 reset resValid", int'(resValid), 0);
    rst = 1'b0;
    drive_cycles(3);

    one_frame(16'hC5A3, 16'hA5C3);
    one_frame(16'h0000, 16'hFFFF);
    one_frame(16'hFFFF, 16'h0000);
    one_frame(16'h2001, 16'h7801);

    // R8: back-to-back frames with the request held high
    ctrlWord = 16'h9C3A;
    devWord  = 16'h3E25;
    startReq = 1'b1;
    wait_idle();
    wait_idle();
    startReq = 1'b0;
    wait_idle();
    drive_cycles(4);

    chk(frames >= 6, "R7 frame count", frames, 6);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule